// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks a victim physical frame when a page must be evicted, using the second-chance (clock) policy over a fixed number of frames. Each frame has a use bit and a lock bit, and a circular hand points at the frame the next scan starts from. Loading a page into a frame, or referencing it, sets that frame's use bit. Lock and unlock commands pin a frame or release it.

When a victim is requested, the block walks the frames in circular order starting at the hand, examining one frame per clock cycle. Locked frames are skipped. An unlocked frame whose use bit is set gets a second chance: its bit is cleared and the scan moves on. The first unlocked frame found with a clear use bit becomes the victim. The block then pulses a valid strobe with the frame index and a write-back flag taken from that frame's dirty bit. If two full revolutions pass with no victim, as happens when every frame is locked, an error pulse is given instead.

The free-frame list and the page transfer are handled elsewhere. The caller supplies the per-frame dirty bits as a vector and loads the new page once the victim is known.

Top module: `clock_victim_selector`

## Requirements
- R1: After reset all use bits and lock bits are 0, the hand is at frame 0, and victimValid, allLockedErr and busy are 0. The first request then selects frame 0.
- R2: A load event (loadValid with frame index loadFrame) sets that frame's use bit to 1 at the next clock edge.
- R3: A reference event (refValid with refFrame) sets that frame's use bit to 1 at the next clock edge, and this also applies while a scan is in progress. When a reference and a scan clear hit the same frame in the same cycle, the reference wins.
- R4: A request sampled at edge c starts a scan at the hand. The scan examines one frame per edge, from c+1 onward, in increasing index order and wraps from NUM_FRAMES-1 to 0. The first unlocked frame with use bit 0 is the victim. If it is the k-th frame examined, victimValid is high for exactly the one cycle after edge c+k, with victimFrame set to its index.
- R5: Every unlocked frame passed over with use bit 1 has its use bit cleared to 0.
- R6: A locked frame is never chosen and is skipped with its use bit unchanged. lockValid/lockFrame sets a lock bit and unlockValid/unlockFrame clears one. If both name the same frame in one cycle, the frame ends up locked.
- R7: victimWriteBack equals frameDirty[victimFrame] as sampled in the cycle that frame was examined (1 means write-back is needed).
- R8: After a victim is chosen, the hand points at the frame after the victim, modulo NUM_FRAMES.
- R9: If 2*NUM_FRAMES frames are examined without finding a victim, allLockedErr pulses for one cycle after the edge of the last examination, victimValid stays low, and the hand is back where the scan started.
- R10: busy is high from the edge after a request is accepted until the result edge, and is low in the result cycle. A request made while busy is ignored and produces no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | A page was loaded into loadFrame |
| loadFrame | input | FRAME_W | Frame index of the load event |
| refValid | input | 1 | A page in refFrame was referenced |
| refFrame | input | FRAME_W | Frame index of the reference |
| lockValid | input | 1 | Pin lockFrame |
| lockFrame | input | FRAME_W | Frame index to lock |
| unlockValid | input | 1 | Release unlockFrame |
| unlockFrame | input | FRAME_W | Frame index to unlock |
| frameDirty | input | NUM_FRAMES | Per-frame modified status |
| victimReq | input | 1 | Request a victim frame |
| busy | output | 1 | A scan is in progress |
| victimValid | output | 1 | One-cycle strobe: victimFrame is valid |
| victimFrame | output | FRAME_W | Index of the chosen frame |
| victimWriteBack | output | 1 | Chosen frame must be written back |
| allLockedErr | output | 1 | One-cycle strobe: no victim found |

## Verification
The assertions assume that every frame index on the event inputs is below NUM_FRAMES. They also assume that the dirty vector seen by the checker one cycle before a result is the one the datapath sampled, which holds because both use the same registered delay. The stimulus only drives indices in range and changes frameDirty between scans, never during one. References that arrive during a scan are timed against the known examination edge, so the expected victim follows from the requirements alone.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scanState_t;

  // Per-cycle commands from the scan control to the frame datapath
  typedef struct packed {
    logic clearUse;  // clear use bit of the frame under the hand
    logic stepHand;  // move the hand one frame forward
    logic capture;   // latch the frame under the hand as victim, step hand
  } scanStrobes_t;

endpackage

// File: rtl/clock_frame_store.sv
module clock_frame_store
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  loadValid,
  input  logic [FRAME_W-1:0]    loadFrame,
  input  logic                  refValid,
  input  logic [FRAME_W-1:0]    refFrame,
  input  logic                  lockValid,
  input  logic [FRAME_W-1:0]    lockFrame,
  input  logic                  unlockValid,
  input  logic [FRAME_W-1:0]    unlockFrame,
  input  logic [NUM_FRAMES-1:0] frameDirty,
  input  scanStrobes_t          strobes,
  output logic                  curUse,
  output logic                  curLock,
  output logic [FRAME_W-1:0]    hand,
  output logic [NUM_FRAMES-1:0] useBits,
  output logic [NUM_FRAMES-1:0] lockBits,
  output logic [FRAME_W-1:0]    victimFrame,
  output logic                  victimWriteBack
);

  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);

  logic [NUM_FRAMES-1:0] useNext;
  logic [NUM_FRAMES-1:0] lockNext;
  logic [FRAME_W-1:0]    handPlusOne;

  // Per-frame next-state: a reference or load overrides a scan clear
  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
    logic isHand;
    logic setUse;
    logic setLock;
    logic clrLock;
    assign isHand  = (hand == FRAME_W'(i));
    assign setUse  = (loadValid && loadFrame == FRAME_W'(i)) ||
                     (refValid && refFrame == FRAME_W'(i));
    assign setLock = lockValid && lockFrame == FRAME_W'(i);
    assign clrLock = unlockValid && unlockFrame == FRAME_W'(i);
    assign useNext[i]  = setUse | (useBits[i] & ~(strobes.clearUse & isHand));
    assign lockNext[i] = setLock | (lockBits[i] & ~clrLock);
  end

  assign handPlusOne = (hand == LAST_FRAME) ? '0 : hand + 1'b1;
  assign curUse      = useBits[hand];
  assign curLock     = lockBits[hand];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      useBits         <= '0;
      lockBits        <= '0;
      hand            <= '0;
      victimFrame     <= '0;
      victimWriteBack <= 1'b0;
    end else begin
      useBits  <= useNext;
      lockBits <= lockNext;
      if (strobes.stepHand || strobes.capture) begin
        hand <= handPlusOne;
      end
      if (strobes.capture) begin
        victimFrame     <= hand;
        victimWriteBack <= frameDirty[hand];
      end
    end
  end

endmodule

// File: rtl/clock_scan_ctrl.sv
module clock_scan_ctrl
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         victimReq,
  input  logic         curUse,
  input  logic         curLock,
  output scanStrobes_t strobes,
  output logic         busy,
  output logic         victimValid,
  output logic         allLockedErr
);

  localparam int SCAN_LIMIT = 2 * NUM_FRAMES;
  localparam int CNT_W      = $clog2(SCAN_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_EXAM = CNT_W'(SCAN_LIMIT - 1);

  scanState_t       state;
  logic [CNT_W-1:0] examCnt;

  // Decision on the frame under the hand
  always_comb begin
    strobes = '0;
    if (state == SCAN_RUN) begin
      if (curLock) begin
        strobes.stepHand = 1'b1;
      end else if (curUse) begin
        strobes.clearUse = 1'b1;
        strobes.stepHand = 1'b1;
      end else begin
        strobes.capture = 1'b1;
      end
    end
  end

  assign busy = (state == SCAN_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= SCAN_IDLE;
      examCnt      <= '0;
      victimValid  <= 1'b0;
      allLockedErr <= 1'b0;
    end else begin
      victimValid  <= 1'b0;
      allLockedErr <= 1'b0;
      case (state)
        SCAN_IDLE: begin
          if (victimReq) begin
            state   <= SCAN_RUN;
            examCnt <= '0;
          end
        end
        SCAN_RUN: begin
          if (strobes.capture) begin
            victimValid <= 1'b1;
            state       <= SCAN_IDLE;
          end else if (examCnt == LAST_EXAM) begin
            allLockedErr <= 1'b1;
            state        <= SCAN_IDLE;
          end else begin
            examCnt <= examCnt + 1'b1;
          end
        end
        default: state <= SCAN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clock_victim_selector.sv
module clock_victim_selector
  import clock_repl_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  loadValid,
  input  logic [FRAME_W-1:0]    loadFrame,
  input  logic                  refValid,
  input  logic [FRAME_W-1:0]    refFrame,
  input  logic                  lockValid,
  input  logic [FRAME_W-1:0]    lockFrame,
  input  logic                  unlockValid,
  input  logic [FRAME_W-1:0]    unlockFrame,
  input  logic [NUM_FRAMES-1:0] frameDirty,
  input  logic                  victimReq,
  output logic                  busy,
  output logic                  victimValid,
  output logic [FRAME_W-1:0]    victimFrame,
  output logic                  victimWriteBack,
  output logic                  allLockedErr
);

  scanStrobes_t          strobes;
  logic                  curUse;
  logic                  curLock;
  logic [FRAME_W-1:0]    hand;
  logic [NUM_FRAMES-1:0] useBits;
  logic [NUM_FRAMES-1:0] lockBits;

  clock_scan_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .victimReq    (victimReq),
    .curUse       (curUse),
    .curLock      (curLock),
    .strobes      (strobes),
    .busy         (busy),
    .victimValid  (victimValid),
    .allLockedErr (allLockedErr)
  );

  clock_frame_store #(.NUM_FRAMES(NUM_FRAMES)) u_store (
    .clk             (clk),
    .rst_n           (rst_n),
    .loadValid       (loadValid),
    .loadFrame       (loadFrame),
    .refValid        (refValid),
    .refFrame        (refFrame),
    .lockValid       (lockValid),
    .lockFrame       (lockFrame),
    .unlockValid     (unlockValid),
    .unlockFrame     (unlockFrame),
    .frameDirty      (frameDirty),
    .strobes         (strobes),
    .curUse          (curUse),
    .curLock         (curLock),
    .hand            (hand),
    .useBits         (useBits),
    .lockBits        (lockBits),
    .victimFrame     (victimFrame),
    .victimWriteBack (victimWriteBack)
  );

endmodule

// File: rtl/clock_victim_checker.sv
module clock_victim_checker #(
  parameter int NUM_FRAMES = 8,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  loadValid,
  input logic [FRAME_W-1:0]    loadFrame,
  input logic                  refValid,
  input logic [FRAME_W-1:0]    refFrame,
  input logic [NUM_FRAMES-1:0] frameDirty,
  input logic                  busy,
  input logic                  victimValid,
  input logic [FRAME_W-1:0]    victimFrame,
  input logic                  victimWriteBack,
  input logic                  allLockedErr,
  input logic [FRAME_W-1:0]    hand,
  input logic [NUM_FRAMES-1:0] useBits,
  input logic [NUM_FRAMES-1:0] lockBits
);

  logic [NUM_FRAMES-1:0] usePrev;
  logic [NUM_FRAMES-1:0] lockPrev;
  logic [NUM_FRAMES-1:0] dirtyPrev;
  logic [FRAME_W-1:0]    afterVictim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usePrev   <= '0;
      lockPrev  <= '0;
      dirtyPrev <= '0;
    end else begin
      usePrev   <= useBits;
      lockPrev  <= lockBits;
      dirtyPrev <= frameDirty;
    end
  end

  assign afterVictim = (victimFrame == FRAME_W'(NUM_FRAMES - 1)) ? '0 : victimFrame + 1'b1;

  p_single_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(victimValid && allLockedErr));

  p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> !lockPrev[victimFrame]);

  p_victim_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> !usePrev[victimFrame]);

  p_hand_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> hand == afterVictim);

  p_writeback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> victimWriteBack == dirtyPrev[victimFrame]);

  p_ref_sets_use_r3: assert property (@(posedge clk) disable iff (!rst_n)
    refValid |=> useBits[$past(refFrame)]);

  p_load_sets_use_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loadValid |=> useBits[$past(loadFrame)]);

  p_result_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (victimValid || allLockedErr) |-> ($past(busy) && !busy));

endmodule

bind clock_victim_selector clock_victim_checker #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .loadValid       (loadValid),
  .loadFrame       (loadFrame),
  .refValid        (refValid),
  .refFrame        (refFrame),
  .frameDirty      (frameDirty),
  .busy            (busy),
  .victimValid     (victimValid),
  .victimFrame     (victimFrame),
  .victimWriteBack (victimWriteBack),
  .allLockedErr    (allLockedErr),
  .hand            (hand),
  .useBits         (useBits),
  .lockBits        (lockBits)
);

// File: tb/clock_victim_selector_tb.sv
module clock_victim_selector_tb;

  localparam int N  = 8;
  localparam int FW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loadValid = 1'b0;
  logic [FW-1:0] loadFrame = '0;
  logic          refValid = 1'b0;
  logic [FW-1:0] refFrame = '0;
  logic          lockValid = 1'b0;
  logic [FW-1:0] lockFrame = '0;
  logic          unlockValid = 1'b0;
  logic [FW-1:0] unlockFrame = '0;
  logic [N-1:0]  frameDirty = '0;
  logic          victimReq = 1'b0;
  logic          busy;
  logic          victimValid;
  logic [FW-1:0] victimFrame;
  logic          victimWriteBack;
  logic          allLockedErr;

  clock_victim_selector #(.NUM_FRAMES(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .loadValid(loadValid), .loadFrame(loadFrame),
    .refValid(refValid), .refFrame(refFrame),
    .lockValid(lockValid), .lockFrame(lockFrame),
    .unlockValid(unlockValid), .unlockFrame(unlockFrame),
    .frameDirty(frameDirty), .victimReq(victimReq),
    .busy(busy), .victimValid(victimValid), .victimFrame(victimFrame),
    .victimWriteBack(victimWriteBack), .allLockedErr(allLockedErr)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checkCnt = 0;
  int failCnt  = 0;
  int cycleCnt = 0;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // Requirement model
  logic [N-1:0] mUse  = '0;
  logic [N-1:0] mLock = '0;
  int           mHand = 0;

  typedef struct {
    int    frame;
    bit    wb;
    bit    err;
    int    cyc;
    string tag;
  } item_t;
  item_t sbq[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pop and compare each result as it appears
  always @(negedge clk) begin
    if (rst_n && (victimValid || allLockedErr)) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R10", "unexpected result", int'(victimFrame), -1);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(cycleCnt == it.cyc, it.tag, "result cycle", cycleCnt, it.cyc);
        check(allLockedErr == it.err, it.tag, "error flag", int'(allLockedErr), int'(it.err));
        check(victimValid == !it.err, it.tag, "valid flag", int'(victimValid), int'(!it.err));
        if (!it.err) begin
          check(int'(victimFrame) == it.frame, it.tag, "victim frame", int'(victimFrame), it.frame);
          check(victimWriteBack == it.wb, "R7", "write-back", int'(victimWriteBack), int'(it.wb));
        end
      end
    end
  end

  task automatic pulseLoad(input int f);
    loadValid = 1'b1; loadFrame = FW'(f); mUse[f] = 1'b1;
    @(negedge clk); loadValid = 1'b0;
  endtask

  task automatic pulseRef(input int f);
    refValid = 1'b1; refFrame = FW'(f); mUse[f] = 1'b1;
    @(negedge clk); refValid = 1'b0;
  endtask

  task automatic pulseLock(input int f);
    lockValid = 1'b1; lockFrame = FW'(f); mLock[f] = 1'b1;
    @(negedge clk); lockValid = 1'b0;
  endtask

  task automatic pulseUnlock(input int f);
    unlockValid = 1'b1; unlockFrame = FW'(f); mLock[f] = 1'b0;
    @(negedge clk); unlockValid = 1'b0;
  endtask

  // R6: lock and unlock on the same frame in one cycle leave it locked
  task automatic lockUnlockSame(input int f);
    lockValid = 1'b1; lockFrame = FW'(f);
    unlockValid = 1'b1; unlockFrame = FW'(f);
    mLock[f] = 1'b1;
    @(negedge clk); lockValid = 1'b0; unlockValid = 1'b0;
  endtask

  // Walk the model from the hand; report victim and frames examined
  task automatic predict(output int frame, output int exam, output bit err);
    frame = 0; err = 1'b1; exam = 2 * N;
    for (int k = 0; k < 2 * N; k++) begin
      int f;
      f = mHand;
      mHand = (f + 1) % N;
      if (mLock[f]) continue;
      if (mUse[f]) begin
        mUse[f] = 1'b0;
        continue;
      end
      frame = f; exam = k + 1; err = 1'b0;
      break;
    end
  endtask

  // Driver: predict, queue the expectation, request, wait out the scan
  task automatic requestVictim(input string tag, input bit extraPulse);
    item_t it;
    int fr, ex;
    bit er;
    predict(fr, ex, er);
    it.frame = fr; it.err = er; it.wb = frameDirty[fr];
    it.cyc = cycleCnt + 1 + ex; it.tag = tag;
    sbq.push_back(it);
    victimReq = 1'b1;
    @(negedge clk);
    victimReq = 1'b0;
    if (extraPulse) begin
      check(busy == 1'b1, "R10", "busy during scan", int'(busy), 1);
      victimReq = 1'b1;   // must be ignored
    end
    @(negedge clk);
    victimReq = 1'b0;
    repeat (ex) @(negedge clk);
    check(busy == 1'b0, "R10", "busy after result", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(victimValid == 1'b0, "R1", "valid in reset", int'(victimValid), 0);
    check(allLockedErr == 1'b0, "R1", "error in reset", int'(allLockedErr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

    frameDirty = 8'b1010_0101;
    requestVictim("R1", 1'b0);        // frame 0, one examination

    pulseLoad(1); pulseLoad(2); pulseLoad(3);
    requestVictim("R5", 1'b0);        // clears 1..3, victim 4 (R2, R8)

    frameDirty = 8'b0110_0000;
    pulseRef(5);
    requestVictim("R3", 1'b0);        // 5 cleared, victim 6, wb 1 (R7)

    pulseLock(7); pulseLock(0);
    requestVictim("R6", 1'b0);        // skips 7 and 0, victim 1

    pulseUnlock(0);
    lockUnlockSame(2);
    requestVictim("R6", 1'b0);        // 2 stays locked, victim 3

    pulseUnlock(7); pulseUnlock(2);
    requestVictim("R10", 1'b1);       // second request ignored

    // R3: a reference during the scan re-marks the first frame passed
    for (int f = 0; f < N; f++) pulseLoad(f);
    begin
      item_t it;
      int h0;
      h0 = mHand;
      it.frame = (h0 + 1) % N; it.err = 1'b0; it.wb = frameDirty[(h0 + 1) % N];
      it.cyc = cycleCnt + 1 + N + 2; it.tag = "R3";
      sbq.push_back(it);
      victimReq = 1'b1;
      @(negedge clk); victimReq = 1'b0;
      @(negedge clk);                  // hand frame examined at the edge just passed
      refValid = 1'b1; refFrame = FW'(h0);
      @(negedge clk); refValid = 1'b0;
      repeat (N + 1) @(negedge clk);
      mUse = '0;
      mHand = (h0 + 2) % N;
    end

    // R9: every frame locked
    pulseLoad(4);
    for (int f = 0; f < N; f++) pulseLock(f);
    requestVictim("R9", 1'b0);
    for (int f = 0; f < N; f++) pulseUnlock(f);
    requestVictim("R9", 1'b0);        // hand unchanged, locked frame use bits kept

    frameDirty = 8'b1111_1111;
    pulseRef(mHand);
    requestVictim("R4", 1'b0);

    repeat (5) @(negedge clk);
    check(sbq.size() == 0, "R10", "pending results", sbq.size(), 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule